// File: doc/BRIEF.md
# Shared Packet Buffer Allocator

This block hands out and takes back a small pool of fixed-size packet buffers that the transmit and receive sides of a network controller share. It holds a bitmap of the buffers in use and three ordered queues of buffer numbers: frames received and waiting for the host, buffers queued to send, and buffers whose transmission has completed. The host drives it through a strobed 3-bit command, a packet-number value and a status-acknowledge write. The receive path asks for a buffer with a one-cycle request, and the transmit side reports each finished frame with a one-cycle pulse.

Four interrupt status bits come from these events: received frame waiting, transmit completed, transmit queue empty and allocation done. They are ANDed with a mask, ORed together and registered to form one interrupt line. If a host allocation finds the pool full, the request stays pending and is granted by the first later buffer release.

Top module: `pkt_pool_alloc`

## Requirements
- R1: After reset the bitmap is all zero, all three queue heads read 0x80, `alloc_result` is 0x00, `int_status` is 0x04 and `irq` is 0.
- R2: An allocation always takes the lowest-numbered free buffer and sets its bitmap bit. Command 1 (allocate for transmit) with a free buffer writes that number to `alloc_result` and sets status bit 3 (value 0x08).
- R3: Command 1 with every buffer in use sets `alloc_result` to 0x80 and clears status bit 3.
- R4: While `alloc_result` is 0x80, every buffer release grants the allocation again: the lowest free buffer is marked used, its number goes to `alloc_result` and status bit 3 is set. A release comes from command 4, command 5 or an automatic release.
- R5: A receive request is granted (`rx_grant` high in the same cycle) only when a buffer is free and the receive queue is not full. The grant appends the buffer to the receive queue and sets status bit 0 (value 0x01).
- R6: Command 3 removes the head of the receive queue. Command 4 also frees that head's buffer. After either, status bit 0 is 1 exactly when entries remain. On an empty queue neither command changes the queues or the bitmap.
- R7: Command 5 frees the buffer named by `pkt_num`. Command 6 appends `pkt_num` to the transmit queue, or is ignored when that queue is full. Both ignore a `pkt_num` at or above the pool size.
- R8: A `tx_sent` pulse removes the head of the transmit queue. With `auto_release` high that buffer is freed; otherwise it is appended to the completed queue if that queue has room. With an empty transmit queue the pulse has no effect.
- R9: Command 2 clears the bitmap and all three queues and sets `alloc_result` to 0x00. Command 7 clears only the transmit and completed queues. Command 0 does nothing.
- R10: Status bit 2 (0x04) is set whenever the transmit queue is empty. Status bit 1 (0x02) is set whenever the completed queue is not empty.
- R11: An acknowledge write clears the status bits in `ack_data & 0xD6`, so bits 0 and 3 are not affected. If `ack_data` bit 1 is set, it also removes the head of the completed queue.
- R12: `irq` equals the OR of `int_status & int_mask` one clock later.
- R13: At most one event takes effect per cycle, in this priority: command, then acknowledge, then `tx_sent`, then receive request. Lower-priority events in the same cycle are ignored.
- R14: Each queue head output shows the oldest entry's buffer number, in first-in first-out order, or 0x80 when the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode, 0 to 7 |
| pkt_num | input | NUMW | Buffer number used by commands 5 and 6 |
| ack_valid | input | 1 | Status acknowledge strobe |
| ack_data | input | 8 | Status bits to clear |
| int_mask | input | 8 | Interrupt enable per status bit |
| tx_sent | input | 1 | Head of the transmit queue has been sent |
| auto_release | input | 1 | Free sent buffers instead of queuing them as completed |
| rx_req | input | 1 | Receive path asks for a buffer |
| rx_grant | output | 1 | Receive request accepted this cycle |
| alloc_result | output | NUMW | Last transmit allocation result, 0x80 on failure |
| rx_head | output | NUMW | Oldest received buffer, or 0x80 |
| tx_head | output | NUMW | Oldest buffer queued to send, or 0x80 |
| done_head | output | NUMW | Oldest completed buffer, or 0x80 |
| buf_map | output | NBUF | Allocation bitmap, bit i set when buffer i is used |
| int_status | output | 8 | Interrupt status bits |
| irq | output | 1 | Registered interrupt line |

## Verification
Some properties are checked on every cycle. The forced transmit-empty and transmit-completed bits track the queue heads. The interrupt line follows the masked status one cycle later. A grant never occurs with a full pool and always leaves a waiting receive entry. At most one buffer becomes used per cycle. A full-pool allocation reports 0x80. A command blocks a receive request in the same cycle. Other behaviour only the bench scenarios can show: lowest-free ordering, the pending allocation being granted by a later release, queue order, the acknowledge side effects and the clear commands. For these, a reference model is compared against every output on every clock.

// File: rtl/pool_pkg.sv
package pool_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_TXALLOC = 3'd1,
    OP_RESET   = 3'd2,
    OP_RXPOP   = 3'd3,
    OP_RXFREE  = 3'd4,
    OP_FREE    = 3'd5,
    OP_TXPUSH  = 3'd6,
    OP_TXCLR   = 3'd7
  } pool_op_e;

  localparam int ST_W       = 8;
  localparam int ST_RX      = 0;
  localparam int ST_TXDONE  = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_ALLOC   = 3;
  localparam logic [ST_W-1:0] ACK_CLEARABLE = 8'hD6;
  localparam logic [ST_W-1:0] ST_RESET_VAL  = 8'h04;
endpackage

// File: rtl/pool_pick.sv
module pool_pick #(
  parameter int NBUF = 4,
  parameter int IDW  = 2
) (
  input  logic [NBUF-1:0] used,
  output logic            found,
  output logic [IDW-1:0]  idx
);
  // lowest-numbered clear bit wins: scan downward so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (!used[i]) begin
        found = 1'b1;
        idx   = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/pool_fifo.sv
module pool_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic [$clog2(DEPTH+1)-1:0]   count_next,
  output logic                         empty,
  output logic                         full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_q, wr_q, rd_n, wr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          pop_ok, push_ok;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign pop_ok  = pop & ~empty;
  assign push_ok = push & (~full | pop_ok);

  always_comb begin
    rd_n  = rd_q;
    wr_n  = wr_q;
    cnt_n = cnt_q;
    if (clr) begin
      rd_n  = '0;
      wr_n  = '0;
      cnt_n = '0;
    end else begin
      if (pop_ok)  rd_n = wrap_inc(rd_q);
      if (push_ok) wr_n = wrap_inc(wr_q);
      cnt_n = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_q] <= din;
  end

  assign head       = mem[rd_q];
  assign count      = cnt_q;
  assign count_next = cnt_n;
endmodule

// File: rtl/pkt_pool_alloc.sv
module pkt_pool_alloc
  import pool_pkg::*;
#(
  parameter int NBUF = 4,
  parameter int NUMW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [NUMW-1:0]   pkt_num,
  input  logic              ack_valid,
  input  logic [ST_W-1:0]   ack_data,
  input  logic [ST_W-1:0]   int_mask,
  input  logic              tx_sent,
  input  logic              auto_release,
  input  logic              rx_req,
  output logic              rx_grant,
  output logic [NUMW-1:0]   alloc_result,
  output logic [NUMW-1:0]   rx_head,
  output logic [NUMW-1:0]   tx_head,
  output logic [NUMW-1:0]   done_head,
  output logic [NBUF-1:0]   buf_map,
  output logic [ST_W-1:0]   int_status,
  output logic              irq
);
  localparam int IDW = (NBUF > 1) ? $clog2(NBUF) : 1;
  localparam int CW  = $clog2(NBUF + 1);
  localparam logic [NUMW-1:0] NONE = NUMW'(1) << (NUMW - 1);

  logic [NBUF-1:0] map_q, map_n, map_base;
  logic [NUMW-1:0] res_q, res_n;
  logic [ST_W-1:0] st_q, st_n;
  logic            irq_q;

  pool_op_e        op;
  logic            do_cmd, do_ack, do_tx, do_rx;
  logic            pkt_ok;
  logic [IDW-1:0]  pkt_idx;

  logic            rel_en;
  logic [IDW-1:0]  rel_idx;
  logic            pick_found;
  logic [IDW-1:0]  pick_idx;
  logic [NBUF-1:0] pick_bit, rel_bit;

  logic            rx_push, rx_pop, rx_clr, rx_empty, rx_full;
  logic            tx_push, tx_pop, tx_clr, tx_empty, tx_full;
  logic            dn_push, dn_pop, dn_clr, dn_empty, dn_full;
  logic [IDW-1:0]  rx_hidx, tx_hidx, dn_hidx;
  logic [CW-1:0]   rx_cnt, tx_cnt, dn_cnt, rx_cnt_n, tx_cnt_n, dn_cnt_n;

  // one-hot decode of the picked and released buffer numbers
  for (genvar g = 0; g < NBUF; g++) begin : g_onehot
    assign pick_bit[g] = (pick_idx == IDW'(g));
    assign rel_bit[g]  = rel_en && (rel_idx == IDW'(g));
  end

  // one event per cycle: command > acknowledge > transmit done > receive request
  assign op      = pool_op_e'(cmd_op);
  assign do_cmd  = cmd_valid;
  assign do_ack  = ack_valid & ~cmd_valid;
  assign do_tx   = tx_sent & ~cmd_valid & ~ack_valid;
  assign do_rx   = rx_req & ~cmd_valid & ~ack_valid & ~tx_sent;
  assign pkt_ok  = (pkt_num < NUMW'(NBUF));
  assign pkt_idx = pkt_num[IDW-1:0];

  always_comb begin
    rel_en  = 1'b0;
    rel_idx = '0;
    if (do_cmd && op == OP_RXFREE && !rx_empty) begin
      rel_en  = 1'b1;
      rel_idx = rx_hidx;
    end else if (do_cmd && op == OP_FREE && pkt_ok) begin
      rel_en  = 1'b1;
      rel_idx = pkt_idx;
    end else if (do_tx && !tx_empty && auto_release) begin
      rel_en  = 1'b1;
      rel_idx = tx_hidx;
    end
  end

  assign map_base = map_q & ~rel_bit;

  pool_pick #(.NBUF(NBUF), .IDW(IDW)) u_pick (
    .used (map_base),
    .found(pick_found),
    .idx  (pick_idx)
  );

  always_comb begin
    map_n    = map_base;
    res_n    = res_q;
    st_n     = st_q;
    rx_push  = 1'b0; rx_pop = 1'b0; rx_clr = 1'b0;
    tx_push  = 1'b0; tx_pop = 1'b0; tx_clr = 1'b0;
    dn_push  = 1'b0; dn_pop = 1'b0; dn_clr = 1'b0;
    rx_grant = 1'b0;

    // a pending transmit allocation is granted by any release
    if (rel_en && res_q == NONE && pick_found) begin
      map_n          = map_base | pick_bit;
      res_n          = NUMW'(pick_idx);
      st_n[ST_ALLOC] = 1'b1;
    end

    if (do_cmd) begin
      unique case (op)
        OP_TXALLOC: begin
          st_n[ST_ALLOC] = 1'b0;
          res_n          = NONE;
          if (pick_found) begin
            map_n          = map_base | pick_bit;
            res_n          = NUMW'(pick_idx);
            st_n[ST_ALLOC] = 1'b1;
          end
        end
        OP_RESET: begin
          map_n  = '0;
          res_n  = '0;
          rx_clr = 1'b1;
          tx_clr = 1'b1;
          dn_clr = 1'b1;
        end
        OP_RXPOP, OP_RXFREE: begin
          rx_pop      = 1'b1;
          st_n[ST_RX] = (rx_cnt > CW'(1));
        end
        OP_TXPUSH: tx_push = pkt_ok;
        OP_TXCLR: begin
          tx_clr = 1'b1;
          dn_clr = 1'b1;
        end
        default: ;
      endcase
    end else if (do_ack) begin
      st_n   = st_n & ~(ack_data & ACK_CLEARABLE);
      dn_pop = ack_data[ST_TXDONE];
    end else if (do_tx) begin
      tx_pop  = 1'b1;
      dn_push = ~tx_empty & ~auto_release;
    end else if (do_rx && pick_found && !rx_full) begin
      rx_grant    = 1'b1;
      rx_push     = 1'b1;
      map_n       = map_base | pick_bit;
      st_n[ST_RX] = 1'b1;
    end

    if (tx_cnt_n == '0) st_n[ST_TXEMPTY] = 1'b1;
    if (dn_cnt_n != '0) st_n[ST_TXDONE]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
      res_q <= '0;
      st_q  <= ST_RESET_VAL;
      irq_q <= 1'b0;
    end else begin
      map_q <= map_n;
      res_q <= res_n;
      st_q  <= st_n;
      irq_q <= |(st_q & int_mask);
    end
  end

  pool_fifo #(.DEPTH(NBUF), .W(IDW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .pop(rx_pop),
    .din(pick_idx), .head(rx_hidx), .count(rx_cnt), .count_next(rx_cnt_n),
    .empty(rx_empty), .full(rx_full)
  );

  pool_fifo #(.DEPTH(NBUF), .W(IDW)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .pop(tx_pop),
    .din(pkt_idx), .head(tx_hidx), .count(tx_cnt), .count_next(tx_cnt_n),
    .empty(tx_empty), .full(tx_full)
  );

  pool_fifo #(.DEPTH(NBUF), .W(IDW)) u_dnq (
    .clk(clk), .rst_n(rst_n), .clr(dn_clr), .push(dn_push), .pop(dn_pop),
    .din(tx_hidx), .head(dn_hidx), .count(dn_cnt), .count_next(dn_cnt_n),
    .empty(dn_empty), .full(dn_full)
  );

  assign alloc_result = res_q;
  assign rx_head      = rx_empty ? NONE : NUMW'(rx_hidx);
  assign tx_head      = tx_empty ? NONE : NUMW'(tx_hidx);
  assign done_head    = dn_empty ? NONE : NUMW'(dn_hidx);
  assign buf_map      = map_q;
  assign int_status   = st_q;
  assign irq          = irq_q;
endmodule

// File: rtl/pkt_pool_alloc_chk.sv
module pkt_pool_alloc_chk
  import pool_pkg::*;
#(
  parameter int NBUF = 4,
  parameter int NUMW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic              rx_req,
  input logic [ST_W-1:0]   int_mask,
  input logic              rx_grant,
  input logic [NUMW-1:0]   alloc_result,
  input logic [NUMW-1:0]   rx_head,
  input logic [NUMW-1:0]   tx_head,
  input logic [NUMW-1:0]   done_head,
  input logic [NBUF-1:0]   buf_map,
  input logic [ST_W-1:0]   int_status,
  input logic              irq
);
  localparam logic [NUMW-1:0] NONE = NUMW'(1) << (NUMW - 1);

  a_r10_txempty_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_head == NONE) |-> int_status[ST_TXEMPTY]);

  a_r10_txdone_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (done_head != NONE) |-> int_status[ST_TXDONE]);

  a_r12_irq_follows_mask: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq == |($past(int_status) & $past(int_mask))));

  a_r2_one_new_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(buf_map & ~$past(buf_map)) <= 1);

  a_r2_result_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_result != NONE) |-> (alloc_result < NUMW'(NBUF)));

  a_r5_grant_needs_free: assert property (@(posedge clk) disable iff (!rst_n)
    rx_grant |-> !(&buf_map));

  a_r5_grant_queues_rx: assert property (@(posedge clk) disable iff (!rst_n)
    rx_grant |=> (int_status[ST_RX] && rx_head != NONE));

  a_r3_full_alloc_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_TXALLOC && (&buf_map)) |=> (alloc_result == NONE));

  a_r13_cmd_blocks_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && rx_req) |-> !rx_grant);
endmodule

bind pkt_pool_alloc pkt_pool_alloc_chk #(.NBUF(NBUF), .NUMW(NUMW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .rx_req(rx_req), .int_mask(int_mask), .rx_grant(rx_grant),
  .alloc_result(alloc_result), .rx_head(rx_head), .tx_head(tx_head),
  .done_head(done_head), .buf_map(buf_map), .int_status(int_status), .irq(irq)
);

// File: tb/tb_pkt_pool_alloc.sv
module tb_pkt_pool_alloc;
  localparam int NBUF = 4;
  localparam int NUMW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, ack_valid = 0, tx_sent = 0, auto_release = 0, rx_req = 0;
  logic [2:0] cmd_op = 0;
  logic [7:0] pkt_num = 0, ack_data = 0, int_mask = 0;
  logic rx_grant, irq;
  logic [7:0] alloc_result, rx_head, tx_head, done_head, int_status;
  logic [NBUF-1:0] buf_map;

  always #5 clk = ~clk;

  pkt_pool_alloc #(.NBUF(NBUF), .NUMW(NUMW)) dut (.*);

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  // reference model state
  int m_map, m_res, m_st;
  bit m_irq;
  int rxq[$], txq[$], dq[$];

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int pick(int m);
    for (int i = 0; i < NBUF; i++) if (((m >> i) & 1) == 0) return i;
    return -1;
  endfunction

  function automatic int hd(ref int q[$]);
    return (q.size() == 0) ? 128 : q[0];
  endfunction

  task automatic m_release(int b);
    int p;
    m_map &= ~(1 << b);
    if (m_res == 128) begin
      p = pick(m_map);
      if (p >= 0) begin m_map |= (1 << p); m_res = p; m_st |= 8; end
    end
  endtask

  task automatic m_step();
    int p, b;
    m_irq = ((m_st & int_mask) != 0);
    if (cmd_valid) begin
      case (cmd_op)
        3'd1: begin
          m_st &= ~8; m_res = 128; p = pick(m_map);
          if (p >= 0) begin m_map |= (1 << p); m_res = p; m_st |= 8; end
        end
        3'd2: begin m_map = 0; m_res = 0; rxq.delete(); txq.delete(); dq.delete(); end
        3'd3, 3'd4: begin
          if (rxq.size() > 0) begin
            b = rxq.pop_front();
            if (cmd_op == 3'd4) m_release(b);
          end
          if (rxq.size() > 0) m_st |= 1; else m_st &= ~1;
        end
        3'd5: if (pkt_num < NBUF) m_release(pkt_num);
        3'd6: if (pkt_num < NBUF && txq.size() < NBUF) txq.push_back(pkt_num);
        3'd7: begin txq.delete(); dq.delete(); end
        default: ;
      endcase
    end else if (ack_valid) begin
      m_st &= ~(ack_data & 8'hD6);
      if (ack_data[1] && dq.size() > 0) void'(dq.pop_front());
    end else if (tx_sent) begin
      if (txq.size() > 0) begin
        b = txq.pop_front();
        if (auto_release) m_release(b);
        else if (dq.size() < NBUF) dq.push_back(b);
      end
    end else if (rx_req) begin
      p = pick(m_map);
      if (p >= 0 && rxq.size() < NBUF) begin
        m_map |= (1 << p); rxq.push_back(p); m_st |= 1;
      end
    end
    if (txq.size() == 0) m_st |= 4;
    if (dq.size() != 0) m_st |= 2;
  endtask

  task automatic cmp_all(string tag);
    chk(tag, "alloc_result", alloc_result, m_res);
    chk(tag, "int_status", int_status, m_st);
    chk(tag, "irq", irq, m_irq);
    chk(tag, "buf_map", buf_map, m_map);
    chk(tag, "rx_head R14", rx_head, hd(rxq));
    chk(tag, "tx_head R14", tx_head, hd(txq));
    chk(tag, "done_head R14", done_head, hd(dq));
  endtask

  // drive one cycle of stimulus at a falling edge, check grant, model, compare
  task automatic step(string tag, bit cv, int op, int pn, bit av, int ad,
                      bit ts, bit rr, bit ar);
    bit eg;
    cmd_valid = cv; cmd_op = 3'(op); pkt_num = 8'(pn);
    ack_valid = av; ack_data = 8'(ad); tx_sent = ts; rx_req = rr; auto_release = ar;
    #1;
    eg = rr && !cv && !av && !ts && pick(m_map) >= 0 && rxq.size() < NBUF;
    chk(tag, "rx_grant", rx_grant, eg);
    @(posedge clk);
    m_step();
    @(negedge clk);
    cmp_all(tag);
    cmd_valid = 0; ack_valid = 0; tx_sent = 0; rx_req = 0;
  endtask

  task automatic cmd(string tag, int op, int pn = 0);
    step(tag, 1, op, pn, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    if (!done_flag) $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_map = 0; m_res = 0; m_st = 4; m_irq = 0;
    int_mask = 8'h0F;
    repeat (3) @(negedge clk);
    cmp_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    m_step();   // idle edge after release
    cmp_all("R1 after release");

    cmd("R2 first alloc", 1);
    step("R5 rx req", 0, 0, 0, 0, 0, 0, 1, 0);
    step("R5 rx req 2", 0, 0, 0, 0, 0, 0, 1, 0);
    cmd("R2 alloc lowest", 1);
    cmd("R3 alloc full", 1);
    step("R5 rx req full", 0, 0, 0, 0, 0, 0, 1, 0);
    cmd("R4 R6 rx free retries", 4);
    cmd("R6 rx pop last", 3);
    cmd("R6 rx pop empty", 3);
    cmd("R6 rx free empty", 4);
    cmd("R7 tx push 0", 6, 0);
    step("R11 R10 ack txempty", 0, 0, 0, 1, 8'h04, 0, 0, 0);
    cmd("R7 tx push 3", 6, 3);
    cmd("R7 tx push out of range", 6, 9);
    cmd("R7 free out of range", 5, 9);
    step("R8 tx sent keep", 0, 0, 0, 0, 0, 1, 0, 0);
    step("R8 tx sent auto", 0, 0, 0, 0, 0, 1, 0, 1);
    step("R8 tx sent empty", 0, 0, 0, 0, 0, 1, 0, 0);
    step("R11 ack bits 0 3 kept", 0, 0, 0, 1, 8'h09, 0, 0, 0);
    step("R11 ack done pop", 0, 0, 0, 1, 8'h02, 0, 0, 0);
    step("R13 cmd over rx", 1, 0, 0, 0, 0, 0, 1, 0);
    step("R13 ack over tx", 0, 0, 0, 1, 8'h00, 1, 1, 0);
    for (int i = 0; i < 5; i++) cmd("R7 tx fill", 6, i % NBUF);
    cmd("R9 tx clear", 7);
    cmd("R9 nop", 0);
    cmd("R7 free 2", 5, 2);
    cmd("R9 unit reset", 2);
    int_mask = 8'h00;
    step("R12 mask off", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R12 mask off 2", 0, 0, 0, 0, 0, 0, 0, 0);
    int_mask = 8'h0F;

    for (int i = 0; i < 600; i++) begin
      int k;
      k = $urandom_range(0, 9);
      int_mask = 8'($urandom_range(0, 255));
      step("R13 random", k < 4, $urandom_range(0, 7), $urandom_range(0, 5),
           k == 4 || k == 8, $urandom_range(0, 255), k == 5 || k == 9,
           k >= 6, $urandom_range(0, 1));
    end

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule